// File: doc/BRIEF.md
# Peripheral Data Source Emulator

This block stands in for an external I/O device that has a fixed buffer of twelve 32-bit words ready to hand to memory. After synchronous reset is released it counts a parameterised number of clock cycles and then raises a data-ready interrupt. The interrupt stays high until the processor acknowledges it. The interrupt fires only once for each reset.

A DMA controller then fetches the buffer in chunks of four words. It presents a request strobe and a word offset. When the offset is valid, the device places the four words starting at that offset onto a shared 128-bit data bus in the next cycle. It keeps driving them while the request stays high. At all other times it leaves the bus alone. The buffer is loaded at reset with a known pattern, so a bench can check what reaches memory.

The bus is modelled as a data vector plus an output enable. When the enable is low the data vector is held at zero, so the device can be OR-combined or muxed onto a shared bus.

Top module: `periph_data_source`

## Requirements
- R1: While `rst_n` is low, at every clock edge `irq`, `bus_oe` and `bus_data` are cleared to zero, whatever the request inputs are.
- R2: `irq` rises at exactly the `DELAY_CYCLES`-th rising edge after `rst_n` is first seen high (default 300), and not before.
- R3: Once high, `irq` stays high until `irq_ack` is sampled high at an edge; `irq` is low from that edge on.
- R4: `irq` is raised only once per reset, and `irq_ack` while `irq` is low has no effect on when `irq` rises.
- R5: Word i of the buffer is `0xD0000000 + i`, for i from 0 to 11. When `req_valid` is high with `req_ofs` equal to 0, 4 or 8 at an edge, then from that edge `bus_oe` is 1 and lane j (`bus_data[32*j+31:32*j]`, j = 0..3) holds word `req_ofs + j`.
- R6: While `req_valid` stays high, the bus stays driven. A change to another valid offset changes the driven chunk at the next edge.
- R7: When `req_valid` is low at an edge, from that edge `bus_oe` is 0 and `bus_data` is all zeros.
- R8: Any `req_offs` value other than 0, 4 or 8 (for example 2, 12 or 15) is ignored. From that edge `bus_oe` is 0 and `bus_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_ack | input | 1 | Processor acknowledge of the data-ready interrupt |
| req_valid | input | 1 | Chunk request from the DMA controller |
| req_ofs | input | 4 | Word offset of the requested chunk |
| irq | output | 1 | Data-ready interrupt, level |
| bus_oe | output | 1 | High while the device drives the data bus |
| bus_data | output | 128 | Four words of the selected chunk, lane 0 in the low bits |

## Verification
A wrong delay counter shows up only at the interrupt pin. It appears as an edge one cycle early or late, or as a second edge hundreds of cycles later, so the bench times the rise to the exact cycle and then watches for a long quiet stretch. A faulty offset decode or lane mux shows in the cycle after the request. It appears as an enable where none belongs, or as a word whose low bits do not equal its offset plus lane number. A bad buffer word therefore shows on the first request that selects it.

// File: rtl/dsrc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the peripheral data source emulator.
// Assumes a word index fits in 32 bits.
package dsrc_pkg;

    // Content of buffer word idx: base pattern plus index.
    function automatic logic [31:0] pattern_word(input logic [31:0] base, input int unsigned idx);
        return base + 32'(idx);
    endfunction

endpackage

// File: rtl/dsrc_delay_irq.sv
`timescale 1ns/1ps
// Post-reset delay counter and one-shot data-ready interrupt.
// Counts DELAY_CYCLES edges after reset release, then raises irq and holds
// it until ack is sampled. Assumes DELAY_CYCLES >= 1.
module dsrc_delay_irq #(
    parameter int DELAY_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic irq
);
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic             irq_q;

    // Count until the delay expires, fire once, and clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (!fired_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    fired_q <= 1'b1;
                    irq_q   <= 1'b1;
                end
            end
            if (irq_q && ack) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/dsrc_word_buffer.sv
`timescale 1ns/1ps
// Word buffer loaded with a fixed pattern at reset, plus a chunk mux.
// Presents CHUNK consecutive words starting at ofs. Lanes past the end
// read zero. Assumes the caller qualifies ofs before using the chunk.
module dsrc_word_buffer #(
    parameter int          WORD_W    = 32,
    parameter int          NUM_WORDS = 12,
    parameter int          CHUNK     = 4,
    parameter int          OFS_W     = 4,
    parameter logic [31:0] BASE      = 32'hD000_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OFS_W-1:0]        ofs,
    output logic [CHUNK*WORD_W-1:0] chunk
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [WORD_W-1:0] mem_q [NUM_WORDS];

    // Each word reloads its pattern value on reset.
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= WORD_W'(dsrc_pkg::pattern_word(BASE, i));
            end
        end
    end

    // Each output lane reads the word at ofs plus its lane number.
    for (genvar j = 0; j < CHUNK; j++) begin : g_lane
        logic [31:0] idx;
        always_comb begin
            idx = {{(32-OFS_W){1'b0}}, ofs} + 32'(j);
            if (idx < 32'(NUM_WORDS)) begin
                chunk[j*WORD_W +: WORD_W] = mem_q[idx[IDX_W-1:0]];
            end else begin
                chunk[j*WORD_W +: WORD_W] = '0;
            end
        end
    end
endmodule

// File: rtl/dsrc_bus_driver.sv
`timescale 1ns/1ps
// Offset decode and registered bus driver.
// Accepts only chunk-aligned offsets inside the buffer. Drives the chosen
// chunk one edge after a qualifying request, and zero otherwise.
// Assumes CHUNK is a power of two of at least 2.
module dsrc_bus_driver #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 12,
    parameter int CHUNK     = 4,
    parameter int OFS_W     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [OFS_W-1:0]        req_ofs,
    input  logic [CHUNK*WORD_W-1:0] chunk,
    output logic                    oe,
    output logic [CHUNK*WORD_W-1:0] data
);
    localparam int ALIGN_W = $clog2(CHUNK);

    logic ofs_ok;
    logic oe_q;
    logic [CHUNK*WORD_W-1:0] data_q;

    // An offset qualifies when it is aligned and starts inside the buffer.
    always_comb begin
        ofs_ok = (req_ofs[ALIGN_W-1:0] == '0) &&
                 ({{(32-OFS_W){1'b0}}, req_ofs} < 32'(NUM_WORDS));
    end

    // Register the enable and the data; zero the data whenever not driving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            data_q <= '0;
        end else if (req_valid && ofs_ok) begin
            oe_q   <= 1'b1;
            data_q <= chunk;
        end else begin
            oe_q   <= 1'b0;
            data_q <= '0;
        end
    end

    assign oe   = oe_q;
    assign data = data_q;
endmodule

// File: rtl/periph_data_source.sv
`timescale 1ns/1ps
// Peripheral data source emulator: a delayed one-shot data-ready interrupt
// and a twelve-word buffer served in four-word chunks on a shared bus.
// Assumes a synchronous active-low reset and requests from a single DMA
// controller.
module periph_data_source #(
    parameter int          WORD_W       = 32,
    parameter int          NUM_WORDS    = 12,
    parameter int          CHUNK        = 4,
    parameter int          OFS_W        = 4,
    parameter int          DELAY_CYCLES = 300,
    parameter logic [31:0] BASE         = 32'hD000_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    irq_ack,
    input  logic                    req_valid,
    input  logic [OFS_W-1:0]        req_ofs,
    output logic                    irq,
    output logic                    bus_oe,
    output logic [CHUNK*WORD_W-1:0] bus_data
);
    logic [CHUNK*WORD_W-1:0] chunk_w;

    dsrc_delay_irq #(.DELAY_CYCLES(DELAY_CYCLES)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (irq_ack),
        .irq   (irq)
    );

    dsrc_word_buffer #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CHUNK(CHUNK),
        .OFS_W(OFS_W), .BASE(BASE)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .ofs   (req_ofs),
        .chunk (chunk_w)
    );

    dsrc_bus_driver #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CHUNK(CHUNK), .OFS_W(OFS_W)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ofs   (req_ofs),
        .chunk     (chunk_w),
        .oe        (bus_oe),
        .data      (bus_data)
    );
endmodule

// File: rtl/periph_data_source_chk.sv
`timescale 1ns/1ps
// Protocol checker for periph_data_source, attached by bind.
// Keeps its own cycle count since reset to time the interrupt.
module periph_data_source_chk #(
    parameter int          WORD_W       = 32,
    parameter int          CHUNK        = 4,
    parameter int          OFS_W        = 4,
    parameter int          DELAY_CYCLES = 300,
    parameter logic [31:0] BASE         = 32'hD000_0000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    irq_ack,
    input logic                    req_valid,
    input logic [OFS_W-1:0]        req_ofs,
    input logic                    irq,
    input logic                    bus_oe,
    input logic [CHUNK*WORD_W-1:0] bus_data
);
    localparam int CYC_W = $clog2(DELAY_CYCLES + 2);
    localparam logic [CYC_W-1:0] CYC_MAX = CYC_W'(DELAY_CYCLES + 1);

    logic [CYC_W-1:0] cyc_q;

    // Count edges since reset release, saturating past the delay.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cyc_q <= '0;
        else if (cyc_q != CYC_MAX)  cyc_q <= cyc_q + 1'b1;
    end

    assert_irq_on_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cyc_q == CYC_W'(DELAY_CYCLES)));

    assert_irq_clears_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> !irq);

    assert_irq_falls_only_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_ack));

    assert_drive_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(req_valid));

    assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));

    assert_lane0_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_data[WORD_W-1:0] == WORD_W'(BASE + 32'($past(req_ofs)))));
endmodule

bind periph_data_source periph_data_source_chk #(
    .WORD_W(WORD_W), .CHUNK(CHUNK), .OFS_W(OFS_W),
    .DELAY_CYCLES(DELAY_CYCLES), .BASE(BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .req_valid(req_valid),
    .req_ofs(req_ofs), .irq(irq), .bus_oe(bus_oe), .bus_data(bus_data)
);

// File: tb/tb_periph_data_source.sv
`timescale 1ns/1ps
module tb_periph_data_source;
    localparam int DELAY = 300;
    localparam logic [31:0] BASE = 32'hD000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         irq_ack = 1'b0;
    logic         req_valid = 1'b0;
    logic [3:0]   req_ofs = 4'd0;
    logic         irq;
    logic         bus_oe;
    logic [127:0] bus_data;

    int n_checks = 0;
    int n_fail = 0;

    periph_data_source dut (
        .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .req_valid(req_valid),
        .req_ofs(req_ofs), .irq(irq), .bus_oe(bus_oe), .bus_data(bus_data)
    );

    always #10 clk = ~clk;

    // Vector: {req_valid, req_ofs[3:0], expected bus_oe}
    localparam logic [5:0] VEC [13] = '{
        {1'b1, 4'd0,  1'b1}, {1'b1, 4'd4,  1'b1}, {1'b1, 4'd8,  1'b1},
        {1'b1, 4'd8,  1'b1}, {1'b0, 4'd4,  1'b0}, {1'b1, 4'd12, 1'b0},
        {1'b1, 4'd2,  1'b0}, {1'b1, 4'd15, 1'b0}, {1'b1, 4'd4,  1'b1},
        {1'b1, 4'd0,  1'b1}, {1'b0, 4'd0,  1'b0}, {1'b1, 4'd8,  1'b1},
        {1'b1, 4'd9,  1'b0}
    };

    function automatic logic [127:0] exp_chunk(input logic [3:0] ofs);
        logic [127:0] c;
        for (int j = 0; j < 4; j++) c[32*j +: 32] = BASE + 32'(ofs) + 32'(j);
        return c;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit early;
        // R1: reset clears outputs, even with a valid request pending.
        req_valid = 1'b1;
        req_ofs   = 4'd4;
        repeat (3) @(negedge clk);
        check("R1 irq",  128'(irq), 128'd0);
        check("R1 oe",   128'(bus_oe), 128'd0);
        check("R1 data", bus_data, 128'd0);
        req_valid = 1'b0;
        rst_n     = 1'b1;

        // R2/R4: time the interrupt; ack while irq is low has no effect.
        early = 1'b0;
        for (int k = 1; k <= DELAY; k++) begin
            irq_ack = (k >= 10 && k <= 12);
            @(negedge clk);
            if (k < DELAY - 1 && irq) early = 1'b1;
            if (k == DELAY - 1) check("R2 irq low one edge before delay", 128'(irq), 128'd0);
            if (k == DELAY)     check("R2 irq high at delay edge", 128'(irq), 128'd1);
        end
        irq_ack = 1'b0;
        check("R4 no early irq despite early ack", 128'(early), 128'd0);

        // R3: irq holds without ack, then clears on ack.
        repeat (5) @(negedge clk);
        check("R3 irq held without ack", 128'(irq), 128'd1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R3 irq cleared after ack", 128'(irq), 128'd0);

        // R4: one shot per reset.
        early = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (irq) early = 1'b1;
        end
        check("R4 irq not raised again", 128'(early), 128'd0);

        // R5-R8: table of requests, each checked one edge later.
        for (int v = 0; v < 13; v++) begin
            req_valid = VEC[v][5];
            req_ofs   = VEC[v][4:1];
            @(negedge clk);
            if (VEC[v][0]) begin
                check(VEC[v][5] && v == 3 ? "R6 hold" : "R5 chunk", bus_data, exp_chunk(VEC[v][4:1]));
                check("R5 oe", 128'(bus_oe), 128'd1);
            end else begin
                check(VEC[v][5] ? "R8 bad offset" : "R7 idle", bus_data, 128'd0);
                check(VEC[v][5] ? "R8 oe" : "R7 oe", 128'(bus_oe), 128'd0);
            end
        end

        // R6: held over several cycles with a steady request.
        req_valid = 1'b1;
        req_ofs   = 4'd4;
        repeat (4) @(negedge clk);
        check("R6 held chunk", bus_data, exp_chunk(4'd4));

        // R1: reset in the middle of a request drops the bus.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-request oe", 128'(bus_oe), 128'd0);
        check("R1 reset mid-request data", bus_data, 128'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule